// File: doc/BRIEF.md
# Device Reset Sequencer with Bounded Retry

This block brings an external device out of reset through a fixed, timed power-up order. It drives an active-low reset pin low for a minimum hold time. It then keeps the pin low until the clocks feeding the device report stable, and for a further minimum settle time after that. Once the pin is released, the block waits for two intervals: one for the device's clock synthesizer to settle, and one for its serial link to come up.

At the last cycle of the link interval, the block samples three status inputs. These are a reset-timer-expired flag, a vector of interface-clock out-of-lock flags, and a link-PLL-timer-expired flag. The attempt succeeds only if both timer flags are set and no out-of-lock flag is set. A failed attempt drives the pin low again and restarts the whole sequence. After the configured number of attempts, the block gives up and raises a fail flag.

A system controller pulses the start input once and then watches the busy, done and fail flags. All intervals are parameters counted in clock cycles.

Top module: `rst_seq_top`

## Requirements
- R1: After synchronous reset, busy, done and fail are 0, the attempt count is 0 and the device reset pin is low.
- R2: A start pulse while idle begins attempt 1 on the next clock edge. Busy goes high, the pin goes low, and done and fail are cleared.
- R3: In each attempt the pin is low for HOLD_CYC cycles. It then stays low until clk_stable_i is seen high, for at least one cycle, and then for POST_CYC further cycles. When clk_stable_i is already high, the pin is low for exactly HOLD_CYC+1+POST_CYC cycles.
- R4: After release, the pin is high for SYNTH_CYC+LINK_CYC cycles before the attempt ends. The status inputs matter only at the clock edge that ends the last of those cycles; their values at any other time have no effect.
- R5: An attempt passes when tmr_expired_i=1, every bit of lock_lost_i is 0 and pll_expired_i=1. On a pass, busy falls, done rises and the pin stays high.
- R6: A failing attempt that is not the last one starts a new attempt on the next cycle. The pin is driven low again and the attempt count increases by one.
- R7: If attempt MAX_TRIES fails, busy falls, fail rises and the pin is held low.
- R8: A start pulse that arrives while busy has no effect on the sequence, its timing or the attempt count.
- R9: Done and fail are never both set. Each stays set until the next accepted start.
- R10: While idle, the attempt count keeps the number of the last attempt made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| clk_stable_i | input | 1 | Clocks and reference selection to the device are stable |
| tmr_expired_i | input | 1 | Device reset timer has expired |
| lock_lost_i | input | NUM_LOCK | Per-interface clock out-of-lock flags |
| pll_expired_i | input | 1 | Device serial-link PLL timer has expired |
| dev_rst_n_o | output | 1 | Active-low reset to the device |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Sticky: last sequence succeeded |
| fail_o | output | 1 | Sticky: all attempts failed |
| attempt_o | output | $clog2(MAX_TRIES+1) | Number of the current or last attempt |

## Verification
The results follow the accepted start with a fixed latency. Busy and the low pin appear at the first clock edge after start is seen. The pin rises HOLD_CYC+1+POST_CYC cycles into an attempt, or later by however long clk_stable_i is held off. Done or fail appears SYNTH_CYC+LINK_CYC cycles after that; on a retry, the pin falls again at that same edge instead. The bench works out these boundaries for every attempt before it applies start. It then compares pin, busy, attempt, done and fail on each falling clock edge against that schedule. It drives random status values everywhere except the one cycle whose edge samples them, so a sampling point off by one cycle shows up as a wrong pass or fail result.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_HOLD    = 3'd1,
        SEQ_WAITCLK = 3'd2,
        SEQ_SETTLE  = 3'd3,
        SEQ_SYNTH   = 3'd4,
        SEQ_LINK    = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic tmr_ok;
        logic lock_ok;
        logic pll_ok;
    } stat_chk_t;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // bits to hold values 0 .. n-1
    function automatic int unsigned width_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic pin_released(seq_state_e st, logic done);
        return (st == SEQ_SYNTH) || (st == SEQ_LINK) || ((st == SEQ_IDLE) && done);
    endfunction

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/rst_seq_eval.sv
module rst_seq_eval
    import rst_seq_pkg::*;
#(
    parameter int unsigned NUM_LOCK = 4
) (
    input  logic                tmr_expired,
    input  logic [NUM_LOCK-1:0] lock_lost,
    input  logic                pll_expired,
    output logic                pass
);
    stat_chk_t chk;

    always_comb begin
        chk.tmr_ok  = tmr_expired;
        chk.lock_ok = ~|lock_lost;
        chk.pll_ok  = pll_expired;
        pass        = &chk;
    end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYC  = 100,
    parameter int unsigned POST_CYC  = 100,
    parameter int unsigned SYNTH_CYC = 100,
    parameter int unsigned LINK_CYC  = 100,
    parameter int unsigned MAX_TRIES = 3,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned ATT_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clk_stable,
    input  logic             tmr_zero,
    input  logic             pass,
    output seq_state_e       state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic [ATT_W-1:0] attempt,
    output logic             done,
    output logic             fail
);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] POST_LD  = CNT_W'(POST_CYC - 1);
    localparam logic [CNT_W-1:0] SYNTH_LD = CNT_W'(SYNTH_CYC - 1);
    localparam logic [CNT_W-1:0] LINK_LD  = CNT_W'(LINK_CYC - 1);
    localparam logic [ATT_W-1:0] LAST_TRY = ATT_W'(MAX_TRIES);

    seq_state_e       st_n;
    logic [ATT_W-1:0] att_n;
    logic             done_n, fail_n;

    always_comb begin
        st_n     = state;
        att_n    = attempt;
        done_n   = done;
        fail_n   = fail;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            SEQ_IDLE: if (start) begin
                st_n     = SEQ_HOLD;
                tmr_load = 1'b1;
                tmr_val  = HOLD_LD;
                att_n    = ATT_W'(1);
                done_n   = 1'b0;
                fail_n   = 1'b0;
            end
            SEQ_HOLD: if (tmr_zero) st_n = SEQ_WAITCLK;
            SEQ_WAITCLK: if (clk_stable) begin
                st_n     = SEQ_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = POST_LD;
            end
            SEQ_SETTLE: if (tmr_zero) begin
                st_n     = SEQ_SYNTH;
                tmr_load = 1'b1;
                tmr_val  = SYNTH_LD;
            end
            SEQ_SYNTH: if (tmr_zero) begin
                st_n     = SEQ_LINK;
                tmr_load = 1'b1;
                tmr_val  = LINK_LD;
            end
            SEQ_LINK: if (tmr_zero) begin
                if (pass) begin
                    st_n   = SEQ_IDLE;
                    done_n = 1'b1;
                end else if (attempt == LAST_TRY) begin
                    st_n   = SEQ_IDLE;
                    fail_n = 1'b1;
                end else begin
                    st_n     = SEQ_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                    att_n    = attempt + ATT_W'(1);
                end
            end
            default: st_n = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            attempt <= '0;
            done    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            state   <= st_n;
            attempt <= att_n;
            done    <= done_n;
            fail    <= fail_n;
        end
    end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYC  = 100_000,
    parameter int unsigned POST_CYC  = 100_000,
    parameter int unsigned SYNTH_CYC = 1_400_000,
    parameter int unsigned LINK_CYC  = 20_000,
    parameter int unsigned MAX_TRIES = 3,
    parameter int unsigned NUM_LOCK  = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start_i,
    input  logic                             clk_stable_i,
    input  logic                             tmr_expired_i,
    input  logic [NUM_LOCK-1:0]              lock_lost_i,
    input  logic                             pll_expired_i,
    output logic                             dev_rst_n_o,
    output logic                             busy_o,
    output logic                             done_o,
    output logic                             fail_o,
    output logic [$clog2(MAX_TRIES+1)-1:0]   attempt_o
);
    localparam int unsigned ATT_W  = $clog2(MAX_TRIES + 1);
    localparam int unsigned MAX_D  = max4(HOLD_CYC, POST_CYC, SYNTH_CYC, LINK_CYC);
    localparam int unsigned CNT_W  = width_for(MAX_D);

    seq_state_e       state;
    logic             tmr_load, tmr_zero, pass;
    logic [CNT_W-1:0] tmr_val;

    rst_seq_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rst_seq_eval #(.NUM_LOCK(NUM_LOCK)) u_eval (
        .tmr_expired (tmr_expired_i),
        .lock_lost   (lock_lost_i),
        .pll_expired (pll_expired_i),
        .pass        (pass)
    );

    rst_seq_fsm #(
        .HOLD_CYC  (HOLD_CYC),
        .POST_CYC  (POST_CYC),
        .SYNTH_CYC (SYNTH_CYC),
        .LINK_CYC  (LINK_CYC),
        .MAX_TRIES (MAX_TRIES),
        .CNT_W     (CNT_W),
        .ATT_W     (ATT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .clk_stable (clk_stable_i),
        .tmr_zero   (tmr_zero),
        .pass       (pass),
        .state      (state),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .attempt    (attempt_o),
        .done       (done_o),
        .fail       (fail_o)
    );

    assign busy_o      = (state != SEQ_IDLE);
    assign dev_rst_n_o = pin_released(state, done_o);
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int unsigned HOLD_CYC  = 100_000,
    parameter int unsigned POST_CYC  = 100_000,
    parameter int unsigned SYNTH_CYC = 1_400_000,
    parameter int unsigned LINK_CYC  = 20_000,
    parameter int unsigned MAX_TRIES = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           start_i,
    input logic                           dev_rst_n_o,
    input logic                           busy_o,
    input logic                           done_o,
    input logic                           fail_o,
    input logic [$clog2(MAX_TRIES+1)-1:0] attempt_o
);
    localparam int unsigned ATT_W = $clog2(MAX_TRIES + 1);

    logic [31:0] low_run, high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= '0;
        end else begin
            low_run  <= dev_rst_n_o ? '0 : ((low_run  == '1) ? low_run  : low_run  + 32'd1);
            high_run <= dev_rst_n_o ? ((high_run == '1) ? high_run : high_run + 32'd1) : '0;
        end
    end

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fail_o));

    assert_busy_clears_flags_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (!done_o && !fail_o));

    assert_first_attempt_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (attempt_o == ATT_W'(1)));

    assert_attempt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        attempt_o <= ATT_W'(MAX_TRIES));

    assert_fail_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> (attempt_o == ATT_W'(MAX_TRIES) && !dev_rst_n_o));

    assert_release_in_seq_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_rst_n_o) |-> busy_o);

    assert_min_low_time_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_rst_n_o) |-> (low_run >= HOLD_CYC + POST_CYC));

    assert_min_high_time_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (high_run >= SYNTH_CYC + LINK_CYC));

    assert_done_released_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> dev_rst_n_o);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(attempt_o) && $stable(done_o) && $stable(fail_o)));
endmodule

bind rst_seq_top rst_seq_chk #(
    .HOLD_CYC  (HOLD_CYC),
    .POST_CYC  (POST_CYC),
    .SYNTH_CYC (SYNTH_CYC),
    .LINK_CYC  (LINK_CYC),
    .MAX_TRIES (MAX_TRIES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dev_rst_n_o (dev_rst_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .attempt_o   (attempt_o)
);

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;
    localparam int H  = 5;
    localparam int P  = 4;
    localparam int S  = 7;
    localparam int L  = 3;
    localparam int MT = 3;
    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i, clk_stable_i, tmr_expired_i, pll_expired_i;
    logic [NL-1:0] lock_lost_i;
    logic          dev_rst_n_o, busy_o, done_o, fail_o;
    logic [1:0]    attempt_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rst_seq_top #(
        .HOLD_CYC(H), .POST_CYC(P), .SYNTH_CYC(S), .LINK_CYC(L),
        .MAX_TRIES(MT), .NUM_LOCK(NL)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .clk_stable_i(clk_stable_i),
        .tmr_expired_i(tmr_expired_i), .lock_lost_i(lock_lost_i),
        .pll_expired_i(pll_expired_i), .dev_rst_n_o(dev_rst_n_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .attempt_o(attempt_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    task automatic drive_status(bit good, int kind);
        if (good) begin
            tmr_expired_i = 1'b1; lock_lost_i = '0; pll_expired_i = 1'b1;
        end else begin
            tmr_expired_i = 1'b1; lock_lost_i = '0; pll_expired_i = 1'b1;
            case (kind % 3)
                0: tmr_expired_i = 1'b0;
                1: lock_lost_i = NL'(1 << (kind % NL));
                default: pll_expired_i = 1'b0;
            endcase
        end
    endtask

    task automatic drive_junk();
        tmr_expired_i = 1'($urandom);
        lock_lost_i   = NL'($urandom);
        pll_expired_i = 1'($urandom);
    endtask

    function automatic int low_len(int a, int stab);
        int w;
        w = H + 1;
        if (a == 0 && stab > w) w = stab;
        return w + P;
    endfunction

    // pass_at: attempt number that passes (> MT means never)
    // stab: falling edge on which clk_stable rises (0 = already high)
    // jr: nonzero picks a cycle for a start pulse while busy
    task automatic run(int pass_at, int stab, int jr);
        int na, total, junk, kind;
        int lows[MT];
        int ends[MT];
        bit pass;
        pass  = (pass_at <= MT);
        na    = pass ? pass_at : MT;
        total = 0;
        for (int a = 0; a < MT; a++) begin
            lows[a] = low_len(a, stab);
            total   = total + lows[a] + S + L;
            ends[a] = total;
        end
        total = ends[na-1];
        junk  = (jr == 0) ? 0 : 2 + (jr % (total - 1));
        kind  = int'($urandom % 6);

        @(negedge clk);
        clk_stable_i = (stab == 0);
        start_i = 1'b1;
        drive_junk();
        for (int c = 1; c <= total; c++) begin
            int a, o;
            @(negedge clk);
            a = 0;
            while (c > ends[a]) a++;
            o = c - ((a == 0) ? 0 : ends[a-1]);
            chk("R2", "busy", busy_o, 1);
            chk("R9", "done cleared", done_o, 0);
            chk("R9", "fail cleared", fail_o, 0);
            chk((a == 0) ? "R8" : "R6", "attempt", attempt_o, a + 1);
            chk((o > lows[a]) ? "R4" : "R3", "pin", dev_rst_n_o, (o > lows[a]) ? 1 : 0);
            start_i = (c == junk);
            if (stab > 0 && c == stab) clk_stable_i = 1'b1;
            if (c == ends[a]) drive_status((a + 1) >= pass_at, kind + a);
            else drive_junk();
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            chk(pass ? "R5" : "R7", "busy end", busy_o, 0);
            chk(pass ? "R5" : "R7", "done", done_o, pass);
            chk(pass ? "R5" : "R7", "fail", fail_o, !pass);
            chk(pass ? "R5" : "R7", "pin end", dev_rst_n_o, pass);
            chk("R10", "attempt held", attempt_o, na);
            drive_junk();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; clk_stable_i = 1'b1;
        tmr_expired_i = 1'b0; lock_lost_i = '0; pll_expired_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "fail", fail_o, 0);
        chk("R1", "attempt", attempt_o, 0);
        chk("R1", "pin", dev_rst_n_o, 0);

        run(1, 0, 0);       // R5 pass first time
        run(4, 0, 0);       // R7 all attempts fail
        run(2, 0, 7);       // R6 retry then pass, R8 start while busy
        run(3, 12, 5);      // R3 late clock-stable, pass on last try
        run(1, 3, 0);       // R3 clock-stable early inside hold
        run(4, 15, 40);     // R7 with late clocks and ignored start
        for (int i = 0; i < 20; i++) begin
            int pa, st, jr;
            pa = 1 + int'($urandom % 4);
            st = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 15);
            jr = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 500);
            run(pa, st, jr);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule